// File: doc/BRIEF.md
# DMA Descriptor Interrupt Condition Evaluator

This block decides whether a DMA channel should signal its interrupt controller when a descriptor command finishes, or when software halts the channel by clearing its run bit. Each descriptor carries a 2-bit interrupt policy. The policy can suppress the interrupt, force it, or make it depend on a masked comparison of the live channel status against a software-programmed pattern.

The pattern lives in a 32-bit interrupt-select register, which the block owns. Its upper half is a per-bit mask and its lower half holds the compare value. The descriptor engine presents the policy field, the command opcode and the channel status together with a strobe. The block answers one clock later with a single-cycle request pulse. Opcodes at or above the stop opcode never raise a request.

Top module: `dma_irq_eval`

## Requirements
- R1: After reset `irq_req` is low and the select register is zero, so policy 01 fires for any status and policy 10 never fires.
- R2: Policy field value 00 never produces a request.
- R3: Policy field value 11 always produces a request when the opcode is below the stop opcode.
- R4: Policy field value 01 produces a request only when (status AND mask) equals (compare value AND mask).
- R5: Policy field value 10 produces a request only when that masked comparison fails.
- R6: The mask is taken from bits 31:16 of the select register and the compare value from bits 15:0.
- R7: An opcode greater than or equal to STOP_OP (default 7) never produces a request, whatever the policy field holds.
- R8: `irq_req` is registered: it is high for exactly the cycle after a qualifying strobe, and it stays low in any cycle that does not follow a strobe.
- R9: A run-clear strobe is evaluated with the same rules as a completion strobe.
- R10: A completion strobe and a run-clear strobe in the same cycle produce one single-cycle pulse.
- R11: The select register is written as a whole 32-bit word. A strobe in the same cycle as the write is evaluated against the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr_en | input | 1 | Write enable for the interrupt-select register |
| sel_wr_data | input | 32 | New select word: mask in 31:16, compare value in 15:0 |
| cmpl_stb | input | 1 | Descriptor command completed |
| run_clr_stb | input | 1 | Software cleared the channel run bit |
| irq_field | input | 2 | Interrupt policy of the completed descriptor (00 never, 01 if match, 10 if mismatch, 11 always) |
| opcode | input | 4 | Command opcode of the completed descriptor |
| chan_stat | input | 16 | Current channel status word |
| irq_req | output | 1 | One-cycle interrupt request pulse |

## Verification
The assertions assume that the policy field, opcode and status are valid in every cycle in which either strobe is high, and that the inputs are steady across the sampling edge. The bench changes every input only on the falling clock edge and advances exactly one cycle per driver call. This keeps every strobe paired with a fully defined set of operands. The select register is written only through its port, so the bench's shadow copy always matches what the block holds.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  // Per-descriptor interrupt policy (field encoding is fixed)
  typedef enum logic [1:0] {
    POL_NEVER    = 2'b00,
    POL_IF_MATCH = 2'b01,
    POL_IF_MISS  = 2'b10,
    POL_ALWAYS   = 2'b11
  } irq_policy_e;

endpackage

// File: rtl/irq_sel_reg.sv
module irq_sel_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      q <= wdata;
    end
  end

endmodule

// File: rtl/irq_cond_cmp.sv
module irq_cond_cmp #(
  parameter int STAT_W = 16
) (
  input  logic [STAT_W-1:0] stat,
  input  logic [STAT_W-1:0] mask,
  input  logic [STAT_W-1:0] value,
  output logic              match
);

  logic [STAT_W-1:0] bit_ok;

  // a bit passes if it is masked out or agrees with the pattern
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    assign bit_ok[i] = ~mask[i] | ~(stat[i] ^ value[i]);
  end

  assign match = &bit_ok;

endmodule

// File: rtl/irq_policy.sv
module irq_policy
  import dma_irq_pkg::*;
#(
  parameter int OP_W    = 4,
  parameter int STOP_OP = 7
) (
  input  logic [1:0]      field,
  input  logic [OP_W-1:0] opcode,
  input  logic            match,
  output logic            fire
);

  localparam logic [OP_W-1:0] STOP_CODE = OP_W'(STOP_OP);

  irq_policy_e pol;
  logic        op_ok;

  assign pol   = irq_policy_e'(field);
  assign op_ok = (opcode < STOP_CODE);

  always_comb begin
    unique case (pol)
      POL_NEVER:    fire = 1'b0;
      POL_IF_MATCH: fire = op_ok & match;
      POL_IF_MISS:  fire = op_ok & ~match;
      POL_ALWAYS:   fire = op_ok;
      default:      fire = 1'b0;
    endcase
  end

endmodule

// File: rtl/dma_irq_eval.sv
module dma_irq_eval #(
  parameter int STAT_W  = 16,
  parameter int OP_W    = 4,
  parameter int STOP_OP = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_wr_en,
  input  logic [2*STAT_W-1:0] sel_wr_data,
  input  logic                cmpl_stb,
  input  logic                run_clr_stb,
  input  logic [1:0]          irq_field,
  input  logic [OP_W-1:0]     opcode,
  input  logic [STAT_W-1:0]   chan_stat,
  output logic                irq_req
);

  localparam int SEL_W = 2 * STAT_W;

  logic [SEL_W-1:0] sel_q;
  logic             match;
  logic             fire;
  logic             eval_stb;

  irq_sel_reg #(.WIDTH(SEL_W)) u_sel (
    .clk   (clk),
    .rst   (rst),
    .we    (sel_wr_en),
    .wdata (sel_wr_data),
    .q     (sel_q)
  );

  irq_cond_cmp #(.STAT_W(STAT_W)) u_cmp (
    .stat  (chan_stat),
    .mask  (sel_q[SEL_W-1:STAT_W]),
    .value (sel_q[STAT_W-1:0]),
    .match (match)
  );

  irq_policy #(.OP_W(OP_W), .STOP_OP(STOP_OP)) u_pol (
    .field  (irq_field),
    .opcode (opcode),
    .match  (match),
    .fire   (fire)
  );

  // both strobes merge into one evaluation event
  assign eval_stb = cmpl_stb | run_clr_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
    end else begin
      irq_req <= eval_stb & fire;
    end
  end

endmodule

// File: rtl/dma_irq_eval_chk.sv
module dma_irq_eval_chk #(
  parameter int STAT_W  = 16,
  parameter int OP_W    = 4,
  parameter int STOP_OP = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              cmpl_stb,
  input logic              run_clr_stb,
  input logic [1:0]        irq_field,
  input logic [OP_W-1:0]   opcode,
  input logic              irq_req
);

  logic any_stb;
  assign any_stb = cmpl_stb | run_clr_stb;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq_req);

  // R8
  no_orphan_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !any_stb |=> !irq_req);

  // R2
  never_policy_chk: assert property (@(posedge clk) disable iff (rst)
    (any_stb && irq_field == 2'b00) |=> !irq_req);

  // R3
  always_policy_chk: assert property (@(posedge clk) disable iff (rst)
    (any_stb && irq_field == 2'b11 && opcode < OP_W'(STOP_OP)) |=> irq_req);

  // R7
  stop_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (any_stb && opcode >= OP_W'(STOP_OP)) |=> !irq_req);

  // R10
  dual_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (cmpl_stb && run_clr_stb && irq_field == 2'b11 && opcode < OP_W'(STOP_OP))
      |=> irq_req);

endmodule

bind dma_irq_eval dma_irq_eval_chk #(
  .STAT_W (STAT_W),
  .OP_W   (OP_W),
  .STOP_OP(STOP_OP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmpl_stb   (cmpl_stb),
  .run_clr_stb(run_clr_stb),
  .irq_field  (irq_field),
  .opcode     (opcode),
  .irq_req    (irq_req)
);

// File: tb/tb_dma_irq_eval.sv
module tb_dma_irq_eval;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_wr_en = 1'b0;
  logic [31:0] sel_wr_data = '0;
  logic        cmpl_stb = 1'b0;
  logic        run_clr_stb = 1'b0;
  logic [1:0]  irq_field = '0;
  logic [3:0]  opcode = '0;
  logic [15:0] chan_stat = '0;
  logic        irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] model_sel = '0;
  bit    exp_q[$];
  string req_q[$];

  always #5 clk = ~clk;

  dma_irq_eval dut (
    .clk        (clk),
    .rst        (rst),
    .sel_wr_en  (sel_wr_en),
    .sel_wr_data(sel_wr_data),
    .cmpl_stb   (cmpl_stb),
    .run_clr_stb(run_clr_stb),
    .irq_field  (irq_field),
    .opcode     (opcode),
    .chan_stat  (chan_stat),
    .irq_req    (irq_req)
  );

  function automatic bit predict(bit c, bit r, logic [1:0] f,
                                 logic [3:0] op, logic [15:0] st,
                                 logic [31:0] sel);
    bit hit;
    hit = ((st & sel[31:16]) == (sel[15:0] & sel[31:16]));
    if (!(c || r) || op >= 4'd7) return 0;
    case (f)
      2'b00:   return 0;
      2'b01:   return hit;
      2'b10:   return !hit;
      default: return 1;
    endcase
  endfunction

  // driver: one cycle per call, pushes the expected next-cycle output
  task automatic step(bit c, bit r, logic [1:0] f, logic [3:0] op,
                      logic [15:0] st, bit we, logic [31:0] wd, string req);
    @(negedge clk);
    cmpl_stb    = c;
    run_clr_stb = r;
    irq_field   = f;
    opcode      = op;
    chan_stat   = st;
    sel_wr_en   = we;
    sel_wr_data = wd;
    exp_q.push_back(predict(c, r, f, op, st, model_sel));
    req_q.push_back(req);
    if (we) model_sel = wd;
  endtask

  task automatic ev(bit c, logic [1:0] f, logic [3:0] op, logic [15:0] st,
                    string req);
    step(c, !c, f, op, st, 1'b0, 32'h0, req);
  endtask

  task automatic idle(string req);
    step(1'b0, 1'b0, 2'b11, 4'd0, 16'h0, 1'b0, 32'h0, req);
  endtask

  task automatic wr_sel(logic [31:0] v);
    step(1'b0, 1'b0, 2'b11, 4'd0, 16'h0, 1'b1, v, "R11");
  endtask

  // monitor: compares each registered result just after the edge
  always @(posedge clk) begin
    bit    e;
    string rq;
    #1;
    if (exp_q.size() > 0) begin
      e  = exp_q.pop_front();
      rq = req_q.pop_front();
      checks++;
      if (irq_req !== e) begin
        errors++;
        $display("FAIL %s irq_req actual=%b expected=%b at %0t", rq, irq_req, e, $time);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // strobe during reset must not matter
    cmpl_stb  = 1'b1;
    irq_field = 2'b11;
    repeat (3) @(negedge clk);
    cmpl_stb = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (irq_req !== 1'b0) begin
      errors++;
      $display("FAIL R1 irq_req actual=%b expected=0 after reset", irq_req);
    end

    // R1: zero select register -> match always true
    ev(1, 2'b01, 4'd0, 16'hBEEF, "R1");
    ev(1, 2'b10, 4'd1, 16'h1234, "R1");

    // R2
    ev(1, 2'b00, 4'd0, 16'h0000, "R2");
    ev(0, 2'b00, 4'd3, 16'hFFFF, "R2");

    // R3
    wr_sel(32'hFFFF_0000);
    ev(1, 2'b11, 4'd2, 16'h5555, "R3");
    ev(1, 2'b11, 4'd6, 16'h0000, "R3");

    // R4 / R5 with mask 00F0, value 0050
    wr_sel(32'h00F0_0050);
    ev(1, 2'b01, 4'd0, 16'hAB5C, "R4");
    ev(1, 2'b01, 4'd0, 16'h0060, "R4");
    ev(1, 2'b10, 4'd0, 16'h0060, "R5");
    ev(1, 2'b10, 4'd0, 16'hFF5F, "R5");

    // R6: halves swapped give a different decision
    wr_sel(32'h0050_00F0);
    ev(1, 2'b01, 4'd0, 16'h0010, "R6");
    ev(1, 2'b01, 4'd0, 16'h0F50, "R6");
    ev(1, 2'b10, 4'd0, 16'h0040, "R6");

    // R7
    ev(1, 2'b11, 4'd7, 16'h0050, "R7");
    ev(1, 2'b11, 4'd15, 16'h0050, "R7");
    ev(1, 2'b01, 4'd8, 16'h0050, "R7");
    ev(1, 2'b11, 4'd6, 16'h0050, "R7");

    // R8: back-to-back and quiet cycles
    ev(1, 2'b11, 4'd0, 16'h0, "R8");
    ev(1, 2'b11, 4'd0, 16'h0, "R8");
    idle("R8");
    idle("R8");

    // R9: run-clear strobe alone
    ev(0, 2'b01, 4'd3, 16'h0050, "R9");
    ev(0, 2'b10, 4'd3, 16'h0050, "R9");
    ev(0, 2'b11, 4'd7, 16'h0050, "R9");

    // R10: both strobes together -> one pulse
    step(1, 1, 2'b11, 4'd1, 16'h0, 1'b0, 32'h0, "R10");
    idle("R10");

    // R11: strobe coincident with write uses old value
    wr_sel(32'hFFFF_1234);
    step(1, 0, 2'b01, 4'd0, 16'h1234, 1'b1, 32'hFFFF_4321, "R11");
    ev(1, 2'b01, 4'd0, 16'h1234, "R11");
    ev(1, 2'b01, 4'd0, 16'h4321, "R11");

    // mixed random traffic
    for (int i = 0; i < 300; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      if (rv[31:29] == 3'd0) begin
        step(rv[0], rv[1], rv[3:2], rv[7:4], rv[23:8], 1'b1,
             {$urandom} & {8'h00, 8'hFF, 16'hFFFF} | {8'h0F, 24'h0}, "R4");
      end else begin
        step(rv[0], rv[1], rv[3:2], {1'b0, rv[6:4]} + {3'b0, rv[28]},
             rv[23:8] & {8'h00, 8'hFF} | {8'h0F, 8'h00}, 1'b0, 32'h0, "R5");
      end
    end

    idle("R8");
    idle("R8");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule